// File: doc/BRIEF.md
# Configuration Readback Serial Framer

This block sends the contents of a configuration store out as a single serial bit stream when it is asked to. A rising trigger, accepted only once configuration has completed, starts a readback run. The block then walks every frame of the store through a frame/bit read port and emits one bit per rising edge of the readback clock. It wraps the stored data in a fixed framing overlay: a run of high dummy bits, a low start bit before each frame, forced-high positions at the head of the first frame, at the tail of every frame and at the tail of the final frame, and a closing low start bit followed by an 11-bit CRC signature.

A busy output stays high for the whole run and drops once the signature has gone out. The number of frames and the number of bit positions per frame are parameters. The store answers combinationally, so a frame index and a bit index go out and the addressed bit returns in the same cycle.

Top module: `cfg_readback_framer`

## Requirements
- R1: When `rb_trig` rises while the block is idle and `cfg_done` is high, `rb_busy` goes high at that clock edge. Each later rising edge presents one new stream bit on `rb_sdata`.
- R2: The stream opens with five high dummy bits followed by one low start bit.
- R3: Every frame is preceded by one low start bit and carries FRAME_BITS body positions (20 by default), sent from bit index 0 upward.
- R4: Body positions 0 and 1 of frame 0 are always sent high.
- R5: The last four body positions of every frame (indices FRAME_BITS-4 to FRAME_BITS-1) are always sent high.
- R6: The last seven body positions of the final frame (indices FRAME_BITS-7 to FRAME_BITS-1) are always sent high.
- R7: After the final frame, one low start bit is sent and then 11 CRC bits, most significant first. `rb_busy` falls on the edge after the last CRC bit. With default parameters a run is 80 bits long.
- R8: The CRC starts at seed 0x7FF. For each body bit b as transmitted, with fb = crc[10] XOR b, the next value is (crc << 1) XOR (fb ? 0x307 : 0). Dummy and start bits do not enter the CRC.
- R9: A body position that is not forced high carries `mem_data` unchanged, with no inversion, read while `mem_frame` and `mem_bit` hold that frame and bit index.
- R10: A trigger edge during a run has no effect. After a run, a trigger still held high does not start a new run. The trigger must go low and then high again.
- R11: A trigger edge while `cfg_done` is low does not start a run.
- R12: After reset `rb_busy` is low and `rb_sdata` is high. `rb_sdata` stays high whenever `rb_busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rb_clk | input | 1 | Readback clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | High once configuration has completed |
| rb_trig | input | 1 | Readback request; its rising edge starts a run |
| mem_data | input | 1 | Bit returned by the configuration store for the current address |
| mem_frame | output | $clog2(N_FRAMES) | Frame index presented to the store |
| mem_bit | output | $clog2(FRAME_BITS) | Bit index within the frame presented to the store |
| rb_busy | output | 1 | Readback in progress |
| rb_sdata | output | 1 | Serial readback stream |

## Verification
The hardest case to reach from the ports is a trigger that toggles in the middle of a run, and one that is still held high when the run ends. A wrong edge detector can restart the sequence or start a second run without being seen unless the whole stream is compared. The bench drops and raises the trigger several times during one run and leaves it high through the end of another. It compares every bit of both runs against an independently built expected stream. It then watches `rb_busy` for many idle cycles before it allows a fresh low-to-high edge. All-zero and all-one store contents are used to separate the forced-high positions from the stored data.

// File: rtl/cfg_readback_framer.sv
module cfg_readback_framer #(
  parameter int N_FRAMES   = 3,
  parameter int FRAME_BITS = 20,
  parameter int DUMMY_BITS = 5,
  parameter int LEAD_ONES  = 2,
  parameter int CHECK_BITS = 4,
  parameter int TAIL_ONES  = 7,
  parameter int CRC_W      = 11,
  parameter logic [CRC_W-1:0] CRC_POLY = 11'h307,
  parameter logic [CRC_W-1:0] CRC_SEED = 11'h7FF,
  localparam int FW = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1,
  localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic          rb_clk,
  input  logic          rst_n,
  input  logic          cfg_done,
  input  logic          rb_trig,
  input  logic          mem_data,
  output logic [FW-1:0] mem_frame,
  output logic [BW-1:0] mem_bit,
  output logic          rb_busy,
  output logic          rb_sdata
);
  localparam int KMAX = (DUMMY_BITS > CRC_W) ? DUMMY_BITS : CRC_W;
  localparam int KW = $clog2(KMAX + 1);
  localparam logic [BW-1:0] LAST_B   = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] CHK_FROM = BW'(FRAME_BITS - CHECK_BITS);
  localparam logic [BW-1:0] TL_FROM  = BW'(FRAME_BITS - TAIL_ONES);
  localparam logic [BW-1:0] LEAD_TO  = BW'(LEAD_ONES);
  localparam logic [FW-1:0] LAST_F   = FW'(N_FRAMES - 1);
  localparam logic [KW-1:0] DUM_LAST = KW'(DUMMY_BITS - 1);
  localparam logic [KW-1:0] CRC_LAST = KW'(CRC_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_DUMMY, S_FSTART, S_BODY, S_LSTART, S_CRC, S_END} phase_t;

  phase_t           phase;
  logic [FW-1:0]    frame;
  logic [BW-1:0]    bidx;
  logic [KW-1:0]    cnt;
  logic [CRC_W-1:0] crc;
  logic             trig_q;

  wire start      = (phase == S_IDLE) && cfg_done && rb_trig && !trig_q;
  wire last_frame = (frame == LAST_F);
  wire forced     = (bidx >= CHK_FROM) || (frame == '0 && bidx < LEAD_TO) ||
                    (last_frame && bidx >= TL_FROM);
  wire body_bit   = forced | mem_data;
  wire [CRC_W-1:0] crc_next = {crc[CRC_W-2:0], 1'b0} ^
                              (((crc[CRC_W-1] ^ body_bit) != 1'b0) ? CRC_POLY : '0);

  assign mem_frame = frame;
  assign mem_bit   = bidx;

  always_ff @(posedge rb_clk) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      frame    <= '0;
      bidx     <= '0;
      cnt      <= '0;
      crc      <= CRC_SEED;
      trig_q   <= 1'b1;
      rb_busy  <= 1'b0;
      rb_sdata <= 1'b1;
    end else begin
      trig_q <= rb_trig;
      case (phase)
        S_IDLE: if (start) begin
          phase   <= S_DUMMY;
          rb_busy <= 1'b1;
          cnt     <= '0;
          frame   <= '0;
          bidx    <= '0;
          crc     <= CRC_SEED;
        end
        S_DUMMY: begin
          rb_sdata <= 1'b1;
          if (cnt == DUM_LAST) phase <= S_FSTART;
          else cnt <= cnt + 1'b1;
        end
        S_FSTART: begin
          rb_sdata <= 1'b0;
          bidx     <= '0;
          phase    <= S_BODY;
        end
        S_BODY: begin
          rb_sdata <= body_bit;
          crc      <= crc_next;
          if (bidx == LAST_B) begin
            if (last_frame) phase <= S_LSTART;
            else begin
              frame <= frame + 1'b1;
              phase <= S_FSTART;
            end
          end else bidx <= bidx + 1'b1;
        end
        S_LSTART: begin
          rb_sdata <= 1'b0;
          cnt      <= '0;
          phase    <= S_CRC;
        end
        S_CRC: begin
          rb_sdata <= crc[CRC_W-1];
          crc      <= {crc[CRC_W-2:0], 1'b0};
          if (cnt == CRC_LAST) phase <= S_END;
          else cnt <= cnt + 1'b1;
        end
        S_END: begin
          rb_sdata <= 1'b1;
          rb_busy  <= 1'b0;
          phase    <= S_IDLE;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  p_launch_r1: assert property (@(posedge rb_clk) disable iff (!rst_n)
    start |=> rb_busy);
  p_dummy_r2: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (phase == S_DUMMY) |=> rb_sdata);
  p_startbit_r3: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (phase == S_FSTART) |=> !rb_sdata);
  p_lead_r4: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (phase == S_BODY && frame == '0 && bidx < LEAD_TO) |=> rb_sdata);
  p_check_r5: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (phase == S_BODY && bidx >= CHK_FROM) |=> rb_sdata);
  p_tail_r6: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (phase == S_BODY && last_frame && bidx >= TL_FROM) |=> rb_sdata);
  p_close_r7: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (phase == S_LSTART) |=> (!rb_sdata && rb_busy));
  p_end_r7: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (phase == S_END) |=> !rb_busy);
  p_pass_r9: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (phase == S_BODY && !forced) |=> (rb_sdata == $past(mem_data)));
  p_hold_r10: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (rb_busy && phase != S_END) |=> rb_busy);
  p_gate_r11: assert property (@(posedge rb_clk) disable iff (!rst_n)
    (!cfg_done && !rb_busy) |=> !rb_busy);
  p_idle_r12: assert property (@(posedge rb_clk) disable iff (!rst_n)
    !rb_busy |-> rb_sdata);
endmodule

// File: tb/tb_cfg_readback_framer.sv
module tb_cfg_readback_framer;
  localparam int NF = 3;
  localparam int FB = 20;

  logic clk = 0, rst_n = 0, cfg_done = 0, trig = 0;
  logic [1:0] mem_frame;
  logic [4:0] mem_bit;
  logic busy, sdata, mem_data;
  logic [FB-1:0] mem [NF];

  int total = 0, bad = 0;
  logic  q_bit[$];
  string q_tag[$];
  logic  prev_busy = 0;

  always #4 clk = ~clk;

  assign mem_data = mem[mem_frame][mem_bit];

  cfg_readback_framer dut (
    .rb_clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .rb_trig(trig),
    .mem_data(mem_data), .mem_frame(mem_frame), .mem_bit(mem_bit),
    .rb_busy(busy), .rb_sdata(sdata));

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic push(input logic b, input string tag);
    q_bit.push_back(b);
    q_tag.push_back(tag);
  endtask

  task automatic build_expected();
    logic [10:0] c = 11'h7FF;
    for (int i = 0; i < 5; i++) push(1'b1, "R2 dummy");
    for (int f = 0; f < NF; f++) begin
      push(1'b0, "R3 start bit");
      for (int b = 0; b < FB; b++) begin
        logic v;
        string t;
        t = "R9 data";
        v = mem[f][b];
        if (f == 0 && b < 2) begin v = 1'b1; t = "R4 lead"; end
        if (b >= FB - 4) begin v = 1'b1; t = "R5 check"; end
        if (f == NF - 1 && b >= FB - 7) begin v = 1'b1; t = "R6 tail"; end
        push(v, t);
        c = {c[9:0], 1'b0} ^ (((c[10] ^ v) != 1'b0) ? 11'h307 : 11'h000);
      end
    end
    push(1'b0, "R7 closing start");
    for (int i = 10; i >= 0; i--) push(c[i], "R8 crc");
  endtask

  always @(negedge clk) begin
    if (busy && prev_busy) begin
      if (q_bit.size() == 0) begin
        total++; bad++;
        $display("FAIL R7 extra bit actual=%b expected=none", sdata);
      end else begin
        logic e;
        string t;
        e = q_bit.pop_front();
        t = q_tag.pop_front();
        check(sdata, e, t);
      end
    end
    prev_busy <= busy;
  end

  task automatic run(input bit retrig, input bit hold);
    int len;
    build_expected();
    @(negedge clk) trig = 1;
    @(negedge clk);
    check(busy, 1'b1, "R1 busy rises");
    len = 0;
    if (retrig) begin
      repeat (8) @(negedge clk);
      trig = 0;
      repeat (3) @(negedge clk);
      trig = 1;
      repeat (20) @(negedge clk);
      trig = 0;
      @(negedge clk);
      trig = 1;
    end else if (!hold) trig = 0;
    while (busy) begin @(negedge clk); len++; end
    check(q_bit.size() == 0, 1'b1, "R7 stream length");
    check(sdata, 1'b1, "R12 idle high after run");
    if (hold || retrig) begin
      repeat (30) begin
        @(negedge clk);
        check(busy, 1'b0, "R10 held trigger no restart");
      end
    end
    trig = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy, 1'b0, "R12 reset busy");
    check(sdata, 1'b1, "R12 reset sdata");

    for (int f = 0; f < NF; f++) mem[f] = FB'($urandom);
    trig = 1; @(negedge clk); trig = 0;
    repeat (5) begin
      @(negedge clk);
      check(busy, 1'b0, "R11 not configured");
    end
    cfg_done = 1;
    @(negedge clk);

    run(0, 0);
    for (int f = 0; f < NF; f++) mem[f] = '0;
    run(0, 0);
    for (int f = 0; f < NF; f++) mem[f] = '1;
    run(0, 0);
    for (int f = 0; f < NF; f++) mem[f] = {FB/2{2'b10}} ^ FB'(f);
    run(1, 0);
    for (int f = 0; f < NF; f++) mem[f] = FB'($urandom);
    run(0, 1);
    run(0, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule